// File: doc/BRIEF.md
# Deferred Prefetch Abort Pipeline Tracker

This block follows instruction-fetch errors through a short in-order pipeline and turns them into precise exceptions only at the moment they matter. A fetch that comes back with an error does not trap. Instead the instruction slot is marked as poisoned, and that mark moves with the instruction through the decode and execute slots. The abort fires only when the poisoned instruction would actually execute. That means the pipeline is advancing, the instruction passes its condition, and no interrupt is being accepted. If a taken branch flushes the instruction first, or it fails its condition, the mark disappears and nothing is reported.

The block also handles synchronous data-side errors. A load or store that really executes in the execute slot moves into a one-cycle memory-response slot. An error reported there raises a data abort against that exact instruction. A data access that was suppressed by its condition code or by an interrupt can never raise one. Each abort is a single-cycle pulse. It carries the faulting instruction's address for the link value and a kill to every younger slot. When both kinds of abort fall due in the same cycle, the older data access wins.

Top module: `pabt_tracker`

## Requirements
- R1: A fetch accepted with `fetch_err`=1 raises no abort in the cycle of the fetch or in the following cycle, while it sits in the decode slot.
- R2: A poisoned instruction in the execute slot raises `abort_take`=1 with `abort_is_data`=0 and `abort_addr` equal to its fetch address, in a cycle with `advance`=1, `exec_cond_pass`=1 and `irq_take`=0.
- R3: A cycle with `advance`=1 and `flush`=1 discards the decode slot and the fetch offered in that cycle, so a poisoned instruction there never raises an abort.
- R4: A poisoned instruction that reaches execute with `exec_cond_pass`=0, or with `irq_take`=1, is dropped silently. `irq_take`=1 empties every slot.
- R5: `abort_take` lasts exactly one cycle. `kill_younger` is asserted in the same cycle, and every younger instruction is discarded, so it can raise no later abort.
- R6: With `advance`=0 every slot holds its contents and mark, and the fetch inputs are ignored. A held poisoned instruction aborts once `advance` returns to 1.
- R7: `data_err`=1 in the cycle after a load or store executed (`advance`=1, `exec_cond_pass`=1, `irq_take`=0, `exec_is_mem`=1, not poisoned) raises `abort_take`=1 with `abort_is_data`=1 and `abort_addr` equal to that instruction's address. In any other cycle `data_err` has no effect.
- R8: If a data abort and a prefetch abort fall due in the same cycle, only the data abort is reported, and the poisoned instruction is discarded.
- R9: Reset empties every slot. A poisoned instruction present before reset never raises an abort afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | 1 moves the pipeline one step, 0 stalls it |
| fetch_valid | input | 1 | An instruction is offered by fetch |
| fetch_err | input | 1 | The offered fetch returned an error |
| fetch_addr | input | ADDR_W | Address of the offered instruction |
| flush | input | 1 | Taken branch in execute, discards younger work |
| exec_cond_pass | input | 1 | Condition check of the execute-slot instruction passes |
| exec_is_mem | input | 1 | Execute-slot instruction performs a data access |
| irq_take | input | 1 | Interrupt accepted, execute-slot instruction does not execute |
| data_err | input | 1 | Error response for the data access issued in the previous cycle |
| abort_take | output | 1 | Single-cycle abort pulse |
| abort_is_data | output | 1 | 1 for a data abort, 0 for a prefetch abort |
| abort_addr | output | ADDR_W | Address of the faulting instruction |
| kill_younger | output | 1 | Discard all younger pipeline work |

## Verification
A mark lost or misplaced in a slot shows up at the ports as a missing or extra `abort_take`. This appears within the number of advancing cycles it takes that slot to reach execute, which is at most two. A slot that keeps stale contents after a kill shows up as a second abort one or two cycles after the first. A wrongly loaded memory-response slot appears the very next cycle, as an `abort_addr` or `abort_is_data` that does not match the load or store that executed. For these reasons every scenario samples the outputs in each cycle until the pipeline is empty again, not only in the cycle where an abort is expected.

// File: rtl/pabt_pkg.sv
package pabt_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_PREFETCH = 2'd1,
    CAUSE_DATA     = 2'd2
  } abort_cause_e;

  // The older data access outranks a poisoned instruction in execute.
  function automatic abort_cause_e pick_cause(input logic pf_due, input logic dt_due);
    if (dt_due)      return CAUSE_DATA;
    else if (pf_due) return CAUSE_PREFETCH;
    else             return CAUSE_NONE;
  endfunction

  // An instruction really executes only when it moves, passes, is not
  // interrupted and carries no fetch-error mark.
  function automatic logic really_executes(input logic vld, input logic poisoned,
                                           input logic adv, input logic cond,
                                           input logic irq);
    return vld && !poisoned && adv && cond && !irq;
  endfunction

endpackage

// File: rtl/ptag_slot.sv
module ptag_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              in_vld,
  input  logic              in_poison,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              vld,
  output logic              poison,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      poison <= 1'b0;
      addr   <= '0;
    end else if (clear) begin
      vld    <= 1'b0;
      poison <= 1'b0;
    end else if (load) begin
      vld    <= in_vld;
      poison <= in_vld && in_poison;
      addr   <= in_addr;
    end
  end

  // R6: a slot neither cleared nor loaded keeps everything.
  a_r6_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load) |=> ($stable(vld) && $stable(poison) && $stable(addr)));

  // R1: the mark never exists without an instruction.
  a_r1_mark_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    poison |-> vld);

endmodule

// File: rtl/pabt_arbiter.sv
module pabt_arbiter
  import pabt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_vld,
  input  logic              ex_poison,
  input  logic [ADDR_W-1:0] ex_addr,
  input  logic              advance,
  input  logic              cond_pass,
  input  logic              irq_take,
  input  logic              mem_vld,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              data_err,
  output logic              take,
  output abort_cause_e      cause,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              ex_retires
);

  logic pf_due;
  logic dt_due;

  assign pf_due     = ex_vld && ex_poison && advance && cond_pass && !irq_take;
  assign dt_due     = mem_vld && data_err;
  assign cause      = pick_cause(pf_due, dt_due);
  assign take       = (cause != CAUSE_NONE);
  assign fault_addr = (cause == CAUSE_DATA) ? mem_addr : ex_addr;
  assign ex_retires = really_executes(ex_vld, ex_poison, advance, cond_pass, irq_take)
                      && !dt_due;

  // R2: a prefetch abort only on a moving, passing, uninterrupted instruction.
  a_r2_prefetch_at_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == CAUSE_PREFETCH) |-> (advance && cond_pass && !irq_take && ex_vld));

  // R8: a pending data error always wins the cycle.
  a_r8_data_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld && data_err) |-> (cause == CAUSE_DATA && fault_addr == mem_addr));

endmodule

// File: rtl/pabt_tracker.sv
module pabt_tracker
  import pabt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              fetch_valid,
  input  logic              fetch_err,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              flush,
  input  logic              exec_cond_pass,
  input  logic              exec_is_mem,
  input  logic              irq_take,
  input  logic              data_err,
  output logic              abort_take,
  output logic              abort_is_data,
  output logic [ADDR_W-1:0] abort_addr,
  output logic              kill_younger
);

  localparam int EX = DEPTH - 1;

  logic              s_vld    [DEPTH];
  logic              s_poison [DEPTH];
  logic [ADDR_W-1:0] s_addr   [DEPTH];

  logic              slot_clear;
  logic              take_w;
  abort_cause_e      cause_w;
  logic [ADDR_W-1:0] fault_addr_w;
  logic              ex_retires;
  logic              mem_vld;
  logic [ADDR_W-1:0] mem_addr;

  // Any abort, an accepted interrupt or a branch flush empties the slots.
  assign slot_clear = take_w || irq_take || (advance && flush);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      if (g == 0) begin : g_first
        ptag_slot #(.ADDR_W(ADDR_W)) u_slot (
          .clk(clk), .rst_n(rst_n), .clear(slot_clear), .load(advance),
          .in_vld(fetch_valid), .in_poison(fetch_err), .in_addr(fetch_addr),
          .vld(s_vld[g]), .poison(s_poison[g]), .addr(s_addr[g]));
      end else begin : g_next
        ptag_slot #(.ADDR_W(ADDR_W)) u_slot (
          .clk(clk), .rst_n(rst_n), .clear(slot_clear), .load(advance),
          .in_vld(s_vld[g-1]), .in_poison(s_poison[g-1]), .in_addr(s_addr[g-1]),
          .vld(s_vld[g]), .poison(s_poison[g]), .addr(s_addr[g]));
      end
    end
  endgenerate

  pabt_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .ex_vld(s_vld[EX]), .ex_poison(s_poison[EX]), .ex_addr(s_addr[EX]),
    .advance(advance), .cond_pass(exec_cond_pass), .irq_take(irq_take),
    .mem_vld(mem_vld), .mem_addr(mem_addr), .data_err(data_err),
    .take(take_w), .cause(cause_w), .fault_addr(fault_addr_w),
    .ex_retires(ex_retires));

  // Memory-response slot: lives for exactly one cycle after a real access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_vld  <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_vld  <= ex_retires && exec_is_mem;
      mem_addr <= s_addr[EX];
    end
  end

  assign abort_take    = take_w;
  assign abort_is_data = (cause_w == CAUSE_DATA);
  assign abort_addr    = fault_addr_w;
  assign kill_younger  = take_w;

  // R5: the abort is a pulse.
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |=> !abort_take);

  // R5: after a kill no younger work survives.
  a_r5_kill_empties: assert property (@(posedge clk) disable iff (!rst_n)
    kill_younger |=> (!s_vld[0] && !s_vld[EX]));

  // R3: a flush leaves the first slot empty.
  a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && flush) |=> !s_vld[0]);

  // R7: a data abort only follows a load or store that really executed.
  a_r7_data_source: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_take && abort_is_data) |->
      $past(advance && exec_cond_pass && !irq_take && exec_is_mem));

endmodule

// File: tb/tb_pabt_tracker.sv
module tb_pabt_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        advance = 1'b0, fetch_valid = 1'b0, fetch_err = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        flush = 1'b0, exec_cond_pass = 1'b0, exec_is_mem = 1'b0;
  logic        irq_take = 1'b0, data_err = 1'b0;
  logic        abort_take, abort_is_data, kill_younger;
  logic [31:0] abort_addr;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  pabt_tracker #(.ADDR_W(32), .DEPTH(2)) dut (
    .clk(clk), .rst_n(rst_n), .advance(advance), .fetch_valid(fetch_valid),
    .fetch_err(fetch_err), .fetch_addr(fetch_addr), .flush(flush),
    .exec_cond_pass(exec_cond_pass), .exec_is_mem(exec_is_mem),
    .irq_take(irq_take), .data_err(data_err), .abort_take(abort_take),
    .abort_is_data(abort_is_data), .abort_addr(abort_addr),
    .kill_younger(kill_younger));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, settle, leave outputs to sample.
  task automatic step(input logic adv, input logic fv, input logic fe,
                      input logic [31:0] fa, input logic fl, input logic cp,
                      input logic mem, input logic irq, input logic derr);
    @(negedge clk);
    advance = adv; fetch_valid = fv; fetch_err = fe; fetch_addr = fa;
    flush = fl; exec_cond_pass = cp; exec_is_mem = mem; irq_take = irq;
    data_err = derr;
    #3;
  endtask

  task automatic no_take(input string req);
    chk(abort_take == 1'b0, req, {31'd0, abort_take}, 32'd0);
  endtask

  task automatic expect_take(input string req, input logic isd, input logic [31:0] a);
    chk(abort_take == 1'b1, req, {31'd0, abort_take}, 32'd1);
    chk(kill_younger == 1'b1, "R5", {31'd0, kill_younger}, 32'd1);
    chk(abort_is_data == isd, req, {31'd0, abort_is_data}, {31'd0, isd});
    chk(abort_addr == a, req, abort_addr, a);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_reset_state();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    no_take("R9");
    chk(kill_younger == 1'b0, "R9", {31'd0, kill_younger}, 32'd0);
  endtask

  task automatic t_prefetch_basic();
    step(1, 1, 1, 32'h100, 0, 1, 0, 0, 0); no_take("R1");
    step(1, 1, 0, 32'h104, 0, 1, 0, 0, 0); no_take("R1");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       expect_take("R2", 1'b0, 32'h100);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R5");
    idle(2); no_take("R5");
  endtask

  task automatic t_flush();
    step(1, 1, 1, 32'h200, 0, 1, 0, 0, 0); no_take("R1");
    step(1, 1, 1, 32'h204, 1, 1, 0, 0, 0); no_take("R3");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R3");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R3");
  endtask

  task automatic t_cond_fail();
    step(1, 1, 1, 32'h300, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);       no_take("R4");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R4");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R4");
  endtask

  task automatic t_irq();
    // Poisoned instruction meets an interrupt at execute, plus one behind it.
    step(1, 1, 1, 32'h380, 0, 1, 0, 0, 0);
    step(1, 1, 1, 32'h384, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0, 1, 0);       no_take("R4");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R4");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R4");
  endtask

  task automatic t_stall();
    step(1, 1, 1, 32'h400, 0, 1, 0, 0, 0);
    step(1, 1, 0, 32'h404, 0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 1, 32'h4F0, 0, 1, 0, 0, 0); no_take("R6");
    end
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       expect_take("R6", 1'b0, 32'h400);
    idle(3); no_take("R6");
  endtask

  task automatic t_data_abort();
    step(1, 1, 0, 32'h500, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 1, 0, 0);       no_take("R7");
    step(1, 0, 0, 0, 0, 1, 0, 0, 1);       expect_take("R7", 1'b1, 32'h500);
    step(1, 0, 0, 0, 0, 1, 0, 0, 1);       no_take("R7");
  endtask

  task automatic t_data_suppressed();
    // Condition fails on the access.
    step(1, 1, 0, 32'h600, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0, 0, 1);       no_take("R7");
    // Interrupt accepted on the access.
    step(1, 1, 0, 32'h640, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 1, 1, 0);
    step(1, 0, 0, 0, 0, 1, 0, 0, 1);       no_take("R4");
  endtask

  task automatic t_priority();
    step(1, 1, 0, 32'h700, 0, 1, 0, 0, 0);
    step(1, 1, 1, 32'h704, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 1, 0, 0);       no_take("R8");
    step(1, 0, 0, 0, 0, 1, 0, 0, 1);       expect_take("R8", 1'b1, 32'h700);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R8");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R8");
  endtask

  task automatic t_kill_younger();
    step(1, 1, 1, 32'h800, 0, 1, 0, 0, 0);
    step(1, 1, 1, 32'h804, 0, 1, 0, 0, 0);
    step(1, 1, 1, 32'h808, 0, 1, 0, 0, 0); expect_take("R5", 1'b0, 32'h800);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R5");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R5");
  endtask

  task automatic t_reset_mid();
    step(1, 1, 1, 32'h900, 0, 1, 0, 0, 0);
    step(1, 1, 1, 32'h904, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R9");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0);       no_take("R9");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_prefetch_basic();   idle(2);
    t_flush();            idle(2);
    t_cond_fail();        idle(2);
    t_irq();              idle(2);
    t_stall();            idle(2);
    t_data_abort();       idle(2);
    t_data_suppressed();  idle(2);
    t_priority();         idle(2);
    t_kill_younger();     idle(2);
    t_reset_mid();        idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule